// File: doc/BRIEF.md
# Clear-on-Read Interrupt Flag Controller

This block gathers single-cycle event strobes from a packet radio datapath into two 8-bit flag registers. Examples are receive or transmit FIFO overrun, transmit FIFO starvation, preamble found, sync word matched, CRC mismatch, good packet and packet sent. Each flag register has an 8-bit enable register beside it. The active-low interrupt line is pulled low while any flag is set together with its enable bit.

Software reaches the block through a plain address/strobe register port. A read of a flag register returns its contents and empties that register in the same step. If no enabled flag remains set after the read, the interrupt line returns high. Flags are captured whether or not they are enabled, so a polling driver still sees them.

The event strobe `evt_i[k]` drives bit k of the flag register at address 0x03 for k below 8, and bit k-8 of the register at 0x04 for the rest. The suggested mapping for 0x03 is: bit 7 FIFO overrun, bit 6 FIFO starvation, bit 2 packet sent, bit 1 good packet, bit 0 CRC mismatch. For 0x04 it is: bit 7 sync word matched, bit 6 preamble found. The remaining bits are free for other events.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all flags and enables are zero, `irq_n` is high and `reg_rdata` is zero.
- R2: A high `evt_i[k]` sets its flag bit, with bits 0..7 in the register at 0x03 and bits 8..15 as bits 0..7 of the register at 0x04. The flag stays set until a read of that register.
- R3: A read strobe to 0x03 or 0x04 loads the register's current value onto `reg_rdata`, visible from the next cycle, and clears that register on the same clock edge.
- R4: A strobe that arrives in the same cycle as the clearing read of its register is kept. It is set after the read and is not part of the returned value.
- R5: `irq_n` is low exactly when some flag bit and its matching enable bit are both set. It follows a flag change one cycle after the event or the read.
- R6: Flags latch while their enable is zero and leave `irq_n` high. Writing an enable bit for a flag that is already set drives `irq_n` low in the next cycle.
- R7: The enable registers at 0x05 (for 0x03) and 0x06 (for 0x04) take the value of `reg_wdata` on a write strobe and return it on a read.
- R8: Writes to 0x03 and 0x04 have no effect. A read of any address other than 0x03 to 0x06 returns zero and clears nothing.
- R9: Reading one flag register leaves the other flag register unchanged.
- R10: `reg_rdata` holds its last value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 16 | Event strobes, one per flag bit |
| reg_addr | input | 7 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears flag registers) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The checker watches several properties on every cycle. Set flags must stay set unless their register is read. A strobe must appear in the flags one cycle later. A read must return the flag value from the cycle of the strobe, and a quiet read must empty its register. The interrupt line must match the AND of flags and enables. Some behaviours only the directed scenarios show: an event colliding with its clearing read, ignored writes to flag addresses, the zero result of an unmapped read, the isolation between the two banks, and the interrupt turning on when an enable is written for a flag that is already pending.

// File: rtl/irq_pkg.sv
// Package: shared sizes and register addresses for the interrupt flag controller.
// Assumes a byte-wide register port and two flag/enable banks.
package irq_pkg;
    localparam int FLAG_W    = 8;   // bits per flag register
    localparam int NBANK     = 2;   // number of flag/enable register pairs
    localparam int ADDR_W    = 7;   // register address width
    localparam int FLAG_BASE = 3;   // address of the first flag register
    localparam int EN_BASE   = 5;   // address of the first enable register
endpackage

// File: rtl/irq_reg_decode.sv
// Module: irq_reg_decode
// Turns the address/strobe register port into per-bank select strobes.
// Assumes flag and enable registers occupy consecutive addresses per bank.
module irq_reg_decode #(
    parameter int ADDR_W    = irq_pkg::ADDR_W,
    parameter int NBANK     = irq_pkg::NBANK,
    parameter int FLAG_BASE = irq_pkg::FLAG_BASE,
    parameter int EN_BASE   = irq_pkg::EN_BASE
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic [NBANK-1:0]  flag_rd_sel,
    output logic [NBANK-1:0]  en_rd_sel,
    output logic [NBANK-1:0]  en_wr_sel
);
    // One address comparator pair per bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_dec
        localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_BASE + b);
        localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_BASE + b);
        assign flag_rd_sel[b] = rd && (addr == FLAG_A);
        assign en_rd_sel[b]   = rd && (addr == EN_A);
        assign en_wr_sel[b]   = wr && (addr == EN_A);
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Module: irq_flag_bank
// One flag register with its enable register. Events set flags, a read clears
// the flags, and events in the clearing cycle survive. It exposes next-state
// values so the interrupt line can be registered in step with the flags.
module irq_flag_bank #(
    parameter int W = irq_pkg::FLAG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr,
    input  logic         en_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flag_q,
    output logic [W-1:0] en_q,
    output logic [W-1:0] flag_nxt,
    output logic [W-1:0] en_nxt
);
    // Next flags: clear-on-read, but keep any strobe of this cycle.
    always_comb begin
        if (clr) flag_nxt = evt;
        else     flag_nxt = flag_q | evt;
    end

    // Next enables: load on write strobe.
    always_comb begin
        if (en_wr) en_nxt = wdata;
        else       en_nxt = en_q;
    end

    // State registers for flags and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= flag_nxt;
            en_q   <= en_nxt;
        end
    end
endmodule

// File: rtl/irq_line_drv.sv
// Module: irq_line_drv
// Registers the active-low interrupt from next-state flags and enables, so it
// changes on the same edge as the flag registers. Idles high in reset.
module irq_line_drv #(
    parameter int N = irq_pkg::NBANK * irq_pkg::FLAG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag_nxt,
    input  logic [N-1:0] en_nxt,
    output logic         irq_n
);
    logic pending;

    // Any enabled flag pending in the next state.
    always_comb pending = |(flag_nxt & en_nxt);

    // Output register for the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= ~pending;
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
// Module: irq_flag_ctrl (top)
// Clear-on-read interrupt flag controller: NBANK flag/enable register pairs
// behind an address/strobe port, with an active-low interrupt output.
// Assumes single-cycle strobes. Read data is registered and held between reads.
module irq_flag_ctrl #(
    parameter int NBANK     = irq_pkg::NBANK,
    parameter int FLAG_W    = irq_pkg::FLAG_W,
    parameter int ADDR_W    = irq_pkg::ADDR_W,
    parameter int FLAG_BASE = irq_pkg::FLAG_BASE,
    parameter int EN_BASE   = irq_pkg::EN_BASE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NBANK*FLAG_W-1:0] evt_i,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [FLAG_W-1:0]       reg_wdata,
    output logic [FLAG_W-1:0]       reg_rdata,
    output logic                    irq_n
);
    localparam int NBITS = NBANK * FLAG_W;

    logic [NBANK-1:0]             flag_rd_sel;
    logic [NBANK-1:0]             en_rd_sel;
    logic [NBANK-1:0]             en_wr_sel;
    logic [NBANK-1:0][FLAG_W-1:0] flag_q;
    logic [NBANK-1:0][FLAG_W-1:0] en_q;
    logic [NBANK-1:0][FLAG_W-1:0] flag_nxt;
    logic [NBANK-1:0][FLAG_W-1:0] en_nxt;
    logic [FLAG_W-1:0]            rd_val;
    logic [FLAG_W-1:0]            rdata_q;

    irq_reg_decode #(
        .ADDR_W(ADDR_W), .NBANK(NBANK), .FLAG_BASE(FLAG_BASE), .EN_BASE(EN_BASE)
    ) u_dec (
        .addr(reg_addr), .rd(reg_rd), .wr(reg_wr),
        .flag_rd_sel(flag_rd_sel), .en_rd_sel(en_rd_sel), .en_wr_sel(en_wr_sel)
    );

    // One flag/enable pair per bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        irq_flag_bank #(.W(FLAG_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .evt(evt_i[b*FLAG_W +: FLAG_W]),
            .clr(flag_rd_sel[b]),
            .en_wr(en_wr_sel[b]),
            .wdata(reg_wdata),
            .flag_q(flag_q[b]), .en_q(en_q[b]),
            .flag_nxt(flag_nxt[b]), .en_nxt(en_nxt[b])
        );
    end

    irq_line_drv #(.N(NBITS)) u_line (
        .clk(clk), .rst_n(rst_n),
        .flag_nxt(flag_nxt), .en_nxt(en_nxt),
        .irq_n(irq_n)
    );

    // Read multiplexer: selected register, zero for unmapped addresses.
    always_comb begin
        rd_val = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (flag_rd_sel[b]) rd_val = rd_val | flag_q[b];
            if (en_rd_sel[b])   rd_val = rd_val | en_q[b];
        end
    end

    // Read data register, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_val;
    end

    assign reg_rdata = rdata_q;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
// Module: irq_flag_ctrl_chk
// Cycle-by-cycle properties of the flag controller, attached by bind.
module irq_flag_ctrl_chk #(
    parameter int NBANK  = irq_pkg::NBANK,
    parameter int FLAG_W = irq_pkg::FLAG_W,
    parameter int ADDR_W = irq_pkg::ADDR_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NBANK*FLAG_W-1:0] evt_i,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic                    reg_rd,
    input logic [FLAG_W-1:0]       reg_rdata,
    input logic                    irq_n,
    input logic [NBANK*FLAG_W-1:0] flags,
    input logic [NBANK*FLAG_W-1:0] ens
);
    localparam logic [ADDR_W-1:0] A_F0 = ADDR_W'(irq_pkg::FLAG_BASE);
    localparam logic [ADDR_W-1:0] A_F1 = ADDR_W'(irq_pkg::FLAG_BASE + 1);

    logic rd_f0, rd_f1;
    logic [NBANK*FLAG_W-1:0] clr_mask;

    // Clear masks derived from the port strobes (two-bank layout).
    always_comb begin
        rd_f0    = reg_rd && (reg_addr == A_F0);
        rd_f1    = reg_rd && (reg_addr == A_F1);
        clr_mask = '0;
        clr_mask[FLAG_W-1:0] = {FLAG_W{rd_f0}};
        if (NBANK > 1) clr_mask[2*FLAG_W-1:FLAG_W] = {FLAG_W{rd_f1}};
    end

    // Set flags survive unless their register is read.
    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|flags) |=> ((($past(flags) & ~$past(clr_mask)) & ~flags) == '0));

    // A strobe shows up in the flags on the next cycle (also when colliding with a read, R4).
    assert_event_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flags & $past(evt_i)) == $past(evt_i)));

    // A read of the first flag register returns its pre-read value.
    assert_read_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_f0 |=> (reg_rdata == $past(flags[FLAG_W-1:0])));

    // A read with no colliding strobe empties its register.
    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_f0 && (evt_i[FLAG_W-1:0] == '0)) |=> (flags[FLAG_W-1:0] == '0));

    // Interrupt line matches the enabled pending flags.
    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == ((flags & ens) == '0));

    // Read data is held between read strobes.
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
    .NBANK(NBANK), .FLAG_W(FLAG_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_n(irq_n),
    .flags(flag_q), .ens(en_q)
);

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench for irq_flag_ctrl: one task per scenario, each checking itself.
module irq_flag_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_i = '0;
    logic [6:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_n;

    int vectors = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    irq_flag_ctrl uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk); evt_i = m;
        @(negedge clk); evt_i = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
        for (int a = 3; a <= 6; a++) begin
            bus_read(7'(a), d);
            chk("R1 reg", d, 8'h00);
        end
    endtask

    task automatic t_set_hold();
        logic [7:0] d;
        pulse(16'h0084);
        repeat (5) @(negedge clk);
        bus_read(7'h03, d); chk("R2 bank0 held", d, 8'h84);
        bus_read(7'h03, d); chk("R3 cleared", d, 8'h00);
        pulse(16'h4000);
        bus_read(7'h04, d); chk("R2 bank1 map", d, 8'h40);
        @(negedge clk); chk("R10 hold", reg_rdata, 8'h40);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        pulse(16'h0002);
        @(negedge clk); reg_addr = 7'h03; reg_rd = 1'b1; evt_i = 16'h0001;
        @(negedge clk); reg_rd = 1'b0; evt_i = '0;
        chk("R4 returned", reg_rdata, 8'h02);
        bus_read(7'h03, d); chk("R4 kept", d, 8'h01);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        pulse(16'h0002);
        chk("R6 disabled idle", {7'b0, irq_n}, 8'h01);
        bus_write(7'h05, 8'h02);
        chk("R6 late enable", {7'b0, irq_n}, 8'h00);
        bus_read(7'h03, d);
        chk("R6 polled", d, 8'h02);
        chk("R5 release", {7'b0, irq_n}, 8'h01);
        pulse(16'h0001);
        chk("R5 masked", {7'b0, irq_n}, 8'h01);
        bus_read(7'h03, d);
        pulse(16'h0002);
        chk("R5 assert", {7'b0, irq_n}, 8'h00);
        bus_read(7'h03, d);
        chk("R5 clear", {7'b0, irq_n}, 8'h01);
        bus_write(7'h05, 8'h00);
    endtask

    task automatic t_enable_rw();
        logic [7:0] d;
        bus_write(7'h05, 8'hA5);
        bus_write(7'h06, 8'h3C);
        bus_read(7'h05, d); chk("R7 en0", d, 8'hA5);
        bus_read(7'h06, d); chk("R7 en1", d, 8'h3C);
        bus_write(7'h05, 8'h00);
        bus_write(7'h06, 8'h00);
        bus_read(7'h05, d); chk("R7 en0 zero", d, 8'h00);
    endtask

    task automatic t_ignore();
        logic [7:0] d;
        bus_write(7'h03, 8'hFF);
        bus_write(7'h04, 8'hFF);
        bus_read(7'h03, d); chk("R8 write f0", d, 8'h00);
        bus_read(7'h04, d); chk("R8 write f1", d, 8'h00);
        pulse(16'h0101);
        bus_read(7'h10, d); chk("R8 unmapped", d, 8'h00);
        bus_read(7'h03, d); chk("R8 kept f0", d, 8'h01);
        bus_read(7'h04, d); chk("R8 kept f1", d, 8'h01);
    endtask

    task automatic t_bank_iso();
        logic [7:0] d;
        bus_write(7'h06, 8'h80);
        pulse(16'h8001);
        chk("R9 irq", {7'b0, irq_n}, 8'h00);
        bus_read(7'h03, d); chk("R9 f0", d, 8'h01);
        chk("R9 irq kept", {7'b0, irq_n}, 8'h00);
        bus_read(7'h04, d); chk("R9 f1", d, 8'h80);
        chk("R9 irq off", {7'b0, irq_n}, 8'h01);
        bus_write(7'h06, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_hold();
        t_same_cycle();
        t_irq();
        t_enable_rw();
        t_ignore();
        t_bank_iso();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule